// File: doc/BRIEF.md
# Host-to-16-bit NAND Access Adapter

This block connects a host request port to a 16-bit NAND data path. The host issues reads and writes of 8, 16 or 32 bits. Each request becomes one or more 16-bit device cycles on a request/acknowledge device port. A word-granular location counter advances by one for every completed device cycle. There is no byte addressing on the device side. A byte access therefore still costs a full device cycle and moves the counter by one word.

On byte reads only the selected lane returns to the host. The other lane is dropped, so the next access fetches the next device word. On byte writes the unused lane is driven to 0xFF. A side port feeds every device word to an ECC engine. On reads that word is the bus data with any unrequested lane replaced by 0xFF. On writes it is the driven write word. A 32-bit request, including each beat of an incrementing burst, is split into two sequential 16-bit cycles.

Back-pressure on the request stream: a request transfers on a cycle where `hreq_valid` and `hreq_ready` are both high. `hreq_ready` stays low from acceptance until the cycle in which the response pulses, so a held request waits. The response is a single-cycle `hrsp_valid` pulse with no back-pressure, and the host must take it.

The device holds `dev_ack` high for one cycle to complete a cycle. Read data is valid on `dev_rdata` in that cycle.

Top module: `nand16_access_adapter`

## Requirements
- R1: After reset `hreq_ready` is 1, `dev_req`, `hrsp_valid` and `ecc_valid` are 0, and `dev_loc` is 0.
- R2: A request of size byte (`hreq_size`=00) or halfword (01) makes exactly one device cycle. A word request (10) makes exactly two device cycles. Size 11 is never issued.
- R3: `dev_loc` advances by exactly one on each completed device cycle (`dev_req` and `dev_ack` both high), and it wraps modulo 2^LOC_W.
- R4: On a byte read, `hreq_lane`=0 returns device bits 7:0 and lane 1 returns device bits 15:8, in `hrsp_rdata[7:0]`. All higher response bits are 0.
- R5: On a byte write, `hreq_wdata[7:0]` is driven on the selected lane of `dev_wdata` (lane 0 = bits 7:0), and the other lane is 0xFF.
- R6: On a byte read, `ecc_data` carries the requested lane from the bus and 0xFF in the other lane. On halfword and word reads it carries the bus word unchanged.
- R7: `ecc_valid` pulses for one cycle per completed device cycle, for both reads and writes. On writes `ecc_data` equals `dev_wdata`.
- R8: A word request moves the lower halfword first (`hreq_wdata[15:0]`, then `[31:16]`). The read response is {second word, first word}.
- R9: `hreq_ready` is low while a device access is in progress. A request held valid meanwhile is accepted exactly once, after the current response. `dev_req`, `dev_we` and `dev_wdata` stay stable until acknowledged.
- R10: A halfword read returns the device word in `hrsp_rdata[15:0]` with the upper bits 0. A halfword write drives `hreq_wdata[15:0]` unchanged.
- R11: `hrsp_valid` is a one-cycle pulse raised in the cycle after the acknowledge of the request's last device cycle, once per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hreq_valid | input | 1 | Host request valid |
| hreq_ready | output | 1 | Adapter can accept a request |
| hreq_write | input | 1 | 1 = write, 0 = read |
| hreq_size | input | 2 | 00 byte, 01 halfword, 10 word |
| hreq_lane | input | 1 | Host address bit 0: byte lane for byte accesses |
| hreq_wdata | input | HOST_W | Write data, low-aligned for byte and halfword |
| hrsp_valid | output | 1 | One-cycle response pulse |
| hrsp_rdata | output | HOST_W | Read data, valid with hrsp_valid on reads |
| dev_req | output | 1 | Device cycle request, held until acknowledged |
| dev_ack | input | 1 | Device cycle complete |
| dev_we | output | 1 | Device cycle is a write |
| dev_loc | output | LOC_W | Word-granular device location |
| dev_wdata | output | 16 | Device write word |
| dev_rdata | input | 16 | Device read word, valid with dev_ack |
| ecc_valid | output | 1 | ECC feed strobe, one per device cycle |
| ecc_data | output | 16 | ECC feed word |

## Verification
The embedded properties assume the host never issues size code 11 and the device raises `dev_ack` only while `dev_req` is high, for a single cycle. The stimulus drives requests only through a bench task that chooses the three legal sizes. The device model in the bench acknowledges a pending request after a programmable delay and drops the acknowledge at once. Data that returns from the device depends on the location, so any skipped or repeated word is visible in the response and in the ECC feed.

// File: rtl/nand16_pkg.sv
package nand16_pkg;
  localparam int DEV_W = 16;
  localparam int LANE_W = 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10
  } acc_size_e;

  localparam logic [LANE_W-1:0] PAD_BYTE = 8'hFF;
endpackage

// File: rtl/nand16_loc_ctr.sv
module nand16_loc_ctr #(
  parameter int LOC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [LOC_W-1:0] loc
);
  always_ff @(posedge clk) begin
    if (!rst_n) loc <= '0;
    else if (step) loc <= loc + 1'b1;
  end

  // R3
  loc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> loc == $past(loc) + 1'b1);
  // R3
  loc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(loc));
endmodule

// File: rtl/nand16_wr_lanes.sv
module nand16_wr_lanes
  import nand16_pkg::*;
#(
  parameter int HOST_W = 32,
  parameter int BEAT_W = 1
) (
  input  acc_size_e          size,
  input  logic               lane,
  input  logic [BEAT_W-1:0]  beat,
  input  logic [HOST_W-1:0]  wdata,
  output logic [DEV_W-1:0]   dev_word
);
  always_comb begin
    if (size == SZ_BYTE)
      dev_word = lane ? {wdata[LANE_W-1:0], PAD_BYTE} : {PAD_BYTE, wdata[LANE_W-1:0]};
    else
      dev_word = wdata[int'(beat)*DEV_W +: DEV_W];
  end
endmodule

// File: rtl/nand16_rd_lanes.sv
module nand16_rd_lanes
  import nand16_pkg::*;
(
  input  logic              is_wr,
  input  acc_size_e         size,
  input  logic              lane,
  input  logic [DEV_W-1:0]  bus_word,
  input  logic [DEV_W-1:0]  wr_word,
  output logic [DEV_W-1:0]  host_part,
  output logic [DEV_W-1:0]  ecc_word
);
  logic [LANE_W-1:0] picked;

  assign picked = lane ? bus_word[DEV_W-1:LANE_W] : bus_word[LANE_W-1:0];

  always_comb begin
    host_part = bus_word;
    ecc_word  = bus_word;
    if (is_wr) begin
      ecc_word = wr_word;
    end else if (size == SZ_BYTE) begin
      host_part = {{(DEV_W-LANE_W){1'b0}}, picked};
      ecc_word  = lane ? {picked, PAD_BYTE} : {PAD_BYTE, picked};
    end
  end
endmodule

// File: rtl/nand16_seq.sv
module nand16_seq
  import nand16_pkg::*;
#(
  parameter int HOST_W = 32,
  parameter int BEATS  = HOST_W / DEV_W,
  parameter int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hreq_valid,
  output logic               hreq_ready,
  input  logic               hreq_write,
  input  logic [1:0]         hreq_size,
  input  logic               hreq_lane,
  input  logic [HOST_W-1:0]  hreq_wdata,
  output logic               dev_req,
  input  logic               dev_ack,
  output logic               dev_we,
  output acc_size_e          cur_size,
  output logic               cur_lane,
  output logic [BEAT_W-1:0]  cur_beat,
  output logic [HOST_W-1:0]  cur_wdata,
  input  logic [DEV_W-1:0]   host_part,
  output logic               cyc_done,
  output logic               hrsp_valid,
  output logic [HOST_W-1:0]  hrsp_rdata
);
  typedef enum logic {ST_IDLE, ST_BUSY} st_e;
  localparam logic [BEAT_W-1:0] LAST_WORD_BEAT = BEAT_W'(BEATS - 1);

  st_e               state;
  logic              is_wr;
  logic [BEAT_W-1:0] last_beat;
  logic              accept;

  assign hreq_ready = (state == ST_IDLE);
  assign accept     = hreq_valid && hreq_ready;
  assign dev_req    = (state == ST_BUSY);
  assign dev_we     = dev_req && is_wr;
  assign cyc_done   = dev_req && dev_ack;
  assign last_beat  = (cur_size == SZ_WORD) ? LAST_WORD_BEAT : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      is_wr      <= 1'b0;
      cur_size   <= SZ_BYTE;
      cur_lane   <= 1'b0;
      cur_beat   <= '0;
      cur_wdata  <= '0;
      hrsp_valid <= 1'b0;
      hrsp_rdata <= '0;
    end else begin
      hrsp_valid <= 1'b0;
      if (accept) begin
        state      <= ST_BUSY;
        is_wr      <= hreq_write;
        cur_size   <= acc_size_e'(hreq_size);
        cur_lane   <= hreq_lane;
        cur_beat   <= '0;
        cur_wdata  <= hreq_wdata;
        hrsp_rdata <= '0;
      end else if (cyc_done) begin
        if (!is_wr) hrsp_rdata[int'(cur_beat)*DEV_W +: DEV_W] <= host_part;
        if (cur_beat == last_beat) begin
          state      <= ST_IDLE;
          hrsp_valid <= 1'b1;
        end else begin
          cur_beat <= cur_beat + 1'b1;
        end
      end
    end
  end

  // R2
  legal_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hreq_valid |-> hreq_size != 2'b11);
  // R9
  ack_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ack |-> dev_req);
  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_req && !dev_ack |=> dev_req && $stable(dev_we) && $stable(cur_beat));
  // R9
  no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hreq_ready && dev_req));
  // R11
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hrsp_valid |=> !hrsp_valid);
  // R11
  rsp_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hrsp_valid |-> $past(cyc_done));
endmodule

// File: rtl/nand16_access_adapter.sv
module nand16_access_adapter
  import nand16_pkg::*;
#(
  parameter int HOST_W = 32,
  parameter int LOC_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hreq_valid,
  output logic               hreq_ready,
  input  logic               hreq_write,
  input  logic [1:0]         hreq_size,
  input  logic               hreq_lane,
  input  logic [HOST_W-1:0]  hreq_wdata,
  output logic               hrsp_valid,
  output logic [HOST_W-1:0]  hrsp_rdata,
  output logic               dev_req,
  input  logic               dev_ack,
  output logic               dev_we,
  output logic [LOC_W-1:0]   dev_loc,
  output logic [15:0]        dev_wdata,
  input  logic [15:0]        dev_rdata,
  output logic               ecc_valid,
  output logic [15:0]        ecc_data
);
  localparam int BEATS  = HOST_W / DEV_W;
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;

  acc_size_e          cur_size;
  logic               cur_lane;
  logic [BEAT_W-1:0]  cur_beat;
  logic [HOST_W-1:0]  cur_wdata;
  logic [DEV_W-1:0]   host_part;
  logic               cyc_done;

  nand16_seq #(.HOST_W(HOST_W), .BEATS(BEATS), .BEAT_W(BEAT_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .hreq_valid(hreq_valid), .hreq_ready(hreq_ready), .hreq_write(hreq_write),
    .hreq_size(hreq_size), .hreq_lane(hreq_lane), .hreq_wdata(hreq_wdata),
    .dev_req(dev_req), .dev_ack(dev_ack), .dev_we(dev_we),
    .cur_size(cur_size), .cur_lane(cur_lane), .cur_beat(cur_beat),
    .cur_wdata(cur_wdata), .host_part(host_part), .cyc_done(cyc_done),
    .hrsp_valid(hrsp_valid), .hrsp_rdata(hrsp_rdata)
  );

  nand16_wr_lanes #(.HOST_W(HOST_W), .BEAT_W(BEAT_W)) u_wr (
    .size(cur_size), .lane(cur_lane), .beat(cur_beat),
    .wdata(cur_wdata), .dev_word(dev_wdata)
  );

  nand16_rd_lanes u_rd (
    .is_wr(dev_we), .size(cur_size), .lane(cur_lane),
    .bus_word(dev_rdata), .wr_word(dev_wdata),
    .host_part(host_part), .ecc_word(ecc_data)
  );

  nand16_loc_ctr #(.LOC_W(LOC_W)) u_loc (
    .clk(clk), .rst_n(rst_n), .step(cyc_done), .loc(dev_loc)
  );

  assign ecc_valid = cyc_done;

  // R5
  byte_pad_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_we && cur_size == SZ_BYTE |->
      (cur_lane ? dev_wdata[7:0] : dev_wdata[15:8]) == PAD_BYTE);
  // R6
  byte_pad_ecc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_valid && !dev_we && cur_size == SZ_BYTE |->
      (cur_lane ? ecc_data[7:0] : ecc_data[15:8]) == PAD_BYTE);
  // R7
  ecc_wr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_valid && dev_we |-> ecc_data == dev_wdata);
  // R9
  wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_req && !dev_ack |=> $stable(dev_wdata));
endmodule

// File: tb/nand16_access_adapter_bench.sv
module nand16_access_adapter_bench;
  localparam int LOC_W = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hreq_valid = 1'b0;
  logic        hreq_ready;
  logic        hreq_write = 1'b0;
  logic [1:0]  hreq_size = 2'b00;
  logic        hreq_lane = 1'b0;
  logic [31:0] hreq_wdata = '0;
  logic        hrsp_valid;
  logic [31:0] hrsp_rdata;
  logic        dev_req;
  logic        dev_ack = 1'b0;
  logic        dev_we;
  logic [LOC_W-1:0] dev_loc;
  logic [15:0] dev_wdata;
  logic [15:0] dev_rdata = '0;
  logic        ecc_valid;
  logic [15:0] ecc_data;

  int checks = 0;
  int errors = 0;
  int dlat = 0;
  int wcnt = 0;
  int wr_n = 0;
  int ecc_n = 0;
  logic [15:0] wr_log  [64];
  logic [15:0] ecc_log [64];

  always #2.5 clk = ~clk;

  nand16_access_adapter #(.HOST_W(32), .LOC_W(LOC_W)) u_nand16_access_adapter (
    .clk(clk), .rst_n(rst_n),
    .hreq_valid(hreq_valid), .hreq_ready(hreq_ready), .hreq_write(hreq_write),
    .hreq_size(hreq_size), .hreq_lane(hreq_lane), .hreq_wdata(hreq_wdata),
    .hrsp_valid(hrsp_valid), .hrsp_rdata(hrsp_rdata),
    .dev_req(dev_req), .dev_ack(dev_ack), .dev_we(dev_we), .dev_loc(dev_loc),
    .dev_wdata(dev_wdata), .dev_rdata(dev_rdata),
    .ecc_valid(ecc_valid), .ecc_data(ecc_data)
  );

  function automatic logic [15:0] pat(input logic [LOC_W-1:0] loc);
    logic [7:0] l;
    l = 8'(loc);
    return {8'h5A ^ l, 8'hC3 + l};
  endfunction

  // device model
  always @(posedge clk) begin
    if (!rst_n) begin
      dev_ack <= 1'b0;
      wcnt    <= 0;
    end else if (dev_ack) begin
      dev_ack <= 1'b0;
    end else if (dev_req) begin
      if (wcnt >= dlat) begin
        dev_ack   <= 1'b1;
        wcnt      <= 0;
        dev_rdata <= pat(dev_loc);
        if (dev_we) begin
          wr_log[wr_n % 64] <= dev_wdata;
          wr_n <= wr_n + 1;
        end
      end else begin
        wcnt <= wcnt + 1;
      end
    end
  end

  always @(posedge clk) begin
    if (rst_n && ecc_valid) begin
      ecc_log[ecc_n % 64] <= ecc_data;
      ecc_n <= ecc_n + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one host request; returns read data, device cycles, checks hold-off and response timing
  task automatic host_op(input logic wr, input logic [1:0] sz, input logic ln,
                         input logic [31:0] wd, output logic [31:0] rd, output int ncyc);
    int e0;
    int guard;
    logic prev_ack;
    logic busy_ok;
    e0 = ecc_n;
    @(negedge clk);
    while (!hreq_ready) @(negedge clk);
    hreq_valid = 1'b1; hreq_write = wr; hreq_size = sz; hreq_lane = ln; hreq_wdata = wd;
    @(negedge clk);
    hreq_valid = 1'b0;
    busy_ok = 1'b1;
    prev_ack = 1'b0;
    guard = 0;
    while (!hrsp_valid && guard < 100) begin
      if (hreq_ready) busy_ok = 1'b0;
      prev_ack = dev_ack;
      @(negedge clk);
      guard++;
    end
    chk("R9 ready low while busy", 32'(busy_ok), 32'd1);
    chk("R11 response follows last ack", 32'(prev_ack), 32'd1);
    rd = hrsp_rdata;
    @(negedge clk);
    chk("R11 response one cycle", 32'(hrsp_valid), 32'd0);
    ncyc = ecc_n - e0;
  endtask

  task automatic t_reset();
    chk("R1 ready", 32'(hreq_ready), 32'd1);
    chk("R1 dev_req", 32'(dev_req), 32'd0);
    chk("R1 hrsp_valid", 32'(hrsp_valid), 32'd0);
    chk("R1 ecc_valid", 32'(ecc_valid), 32'd0);
    chk("R1 dev_loc", 32'(dev_loc), 32'd0);
  endtask

  task automatic t_byte_reads();
    logic [31:0] rd; int n; logic [LOC_W-1:0] l;
    dlat = 1;
    l = dev_loc;
    host_op(1'b0, 2'b00, 1'b0, '0, rd, n);
    chk("R2 byte read one cycle", 32'(n), 32'd1);
    chk("R4 byte lane0 read", rd, {24'h0, pat(l)[7:0]});
    chk("R6 byte lane0 ecc", 32'(ecc_log[(ecc_n-1)%64]), {16'h0, 8'hFF, pat(l)[7:0]});
    chk("R3 loc step after byte", 32'(dev_loc), 32'(LOC_W'(l + 1)));
    l = dev_loc;
    host_op(1'b0, 2'b00, 1'b1, '0, rd, n);
    chk("R4 byte lane1 read", rd, {24'h0, pat(l)[15:8]});
    chk("R6 byte lane1 ecc", 32'(ecc_log[(ecc_n-1)%64]), {16'h0, pat(l)[15:8], 8'hFF});
    chk("R3 next byte reads next word", 32'(dev_loc), 32'(LOC_W'(l + 1)));
  endtask

  task automatic t_half_read();
    logic [31:0] rd; int n; logic [LOC_W-1:0] l;
    dlat = 0;
    l = dev_loc;
    host_op(1'b0, 2'b01, 1'b0, '0, rd, n);
    chk("R2 half read one cycle", 32'(n), 32'd1);
    chk("R10 half read data", rd, {16'h0, pat(l)});
    chk("R6 half read ecc", 32'(ecc_log[(ecc_n-1)%64]), {16'h0, pat(l)});
  endtask

  task automatic t_word_read();
    logic [31:0] rd; int n; logic [LOC_W-1:0] l;
    dlat = 2;
    l = dev_loc;
    host_op(1'b0, 2'b10, 1'b0, '0, rd, n);
    chk("R2 word read two cycles", 32'(n), 32'd2);
    chk("R8 word read order", rd, {pat(LOC_W'(l + 1)), pat(l)});
    chk("R7 ecc first beat", 32'(ecc_log[(ecc_n-2)%64]), {16'h0, pat(l)});
    chk("R7 ecc second beat", 32'(ecc_log[(ecc_n-1)%64]), {16'h0, pat(LOC_W'(l + 1))});
    chk("R3 loc after word", 32'(dev_loc), 32'(LOC_W'(l + 2)));
  endtask

  task automatic t_writes();
    logic [31:0] rd; int n; int w0;
    dlat = 1;
    w0 = wr_n;
    host_op(1'b1, 2'b00, 1'b0, 32'hAAAA_BB3E, rd, n);
    chk("R5 byte lane0 write", 32'(wr_log[w0 % 64]), 32'h0000_FF3E);
    chk("R7 ecc on write", 32'(ecc_log[(ecc_n-1)%64]), 32'h0000_FF3E);
    chk("R2 byte write one cycle", 32'(n), 32'd1);
    host_op(1'b1, 2'b00, 1'b1, 32'h0000_0071, rd, n);
    chk("R5 byte lane1 write", 32'(wr_log[(w0+1) % 64]), 32'h0000_71FF);
    host_op(1'b1, 2'b01, 1'b0, 32'h1111_BEEF, rd, n);
    chk("R10 half write", 32'(wr_log[(w0+2) % 64]), 32'h0000_BEEF);
    host_op(1'b1, 2'b10, 1'b0, 32'h1234_5678, rd, n);
    chk("R2 word write two cycles", 32'(n), 32'd2);
    chk("R8 word write low first", 32'(wr_log[(w0+3) % 64]), 32'h0000_5678);
    chk("R8 word write high second", 32'(wr_log[(w0+4) % 64]), 32'h0000_1234);
    chk("R7 ecc write count", 32'(wr_n - w0), 32'd5);
  endtask

  // incrementing burst of word reads with request held valid through busy periods
  task automatic t_burst(input int beats);
    int got; int e0; int guard; logic [LOC_W-1:0] l; logic busy_ok;
    dlat = 0;
    @(negedge clk);
    while (!hreq_ready) @(negedge clk);
    l = dev_loc; e0 = ecc_n; got = 0; guard = 0; busy_ok = 1'b1;
    hreq_valid = 1'b1; hreq_write = 1'b0; hreq_size = 2'b10; hreq_lane = 1'b0;
    @(negedge clk);
    while (got < beats && guard < 500) begin
      if (hrsp_valid) begin
        chk("R8 burst beat data", hrsp_rdata,
            {pat(LOC_W'(l + LOC_W'(2*got + 1))), pat(LOC_W'(l + LOC_W'(2*got)))});
        got++;
        if (got == beats) hreq_valid = 1'b0;
      end else if (hreq_ready) begin
        busy_ok = 1'b0;
      end
      @(negedge clk);
      guard++;
    end
    hreq_valid = 1'b0;
    repeat (6) @(negedge clk);
    chk("R9 held request not repeated", 32'(ecc_n - e0), 32'(2*beats));
    chk("R9 ready low during burst beats", 32'(busy_ok), 32'd1);
    chk("R3 loc after burst wraps", 32'(dev_loc), 32'(LOC_W'(l + LOC_W'(2*beats))));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_byte_reads();
    t_half_read();
    t_word_read();
    t_writes();
    t_burst(9);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule